// File: doc/BRIEF.md
# I2C master controller with registers

This block is a single-master I2C controller that software drives through four byte-wide registers: control, status/mode, data shift and own address. Software places a byte in the data register, picks a direction in the status register and asks for a START or a STOP by writing a mode code with the busy bit set or cleared. The block drives the bus conditions, shifts the byte MSB first and handles the acknowledge bit. It then raises a pending flag and keeps SCL low until software writes 1 to that flag.

The SCL period is set by a prescaler of 16 or 512 and a 4-bit divisor. Each SCL bit is cut into four equal quarters: set data, raise SCL, sample, lower SCL. Because a new START is only taken from an idle bus, software can issue a repeated START by writing the receive start code while the bus is still held. Writing 0 to the ACK-enable bit before releasing a received byte makes the controller answer that byte with NAK.

Top module: `i2c_master_regs`

## Requirements
- R1: After reset, control, status, data and own-address registers read 0x00. scl_o and sda_o are 1 and irq_o is 0.
- R2: A status write with bit 5 (busy) and bit 4 (output enable) both set, made while the bus is idle, produces a START. The data register byte then goes out MSB first. After the ninth bit, control bit 4 (pending) reads 1 and status bit 0 holds the slave's acknowledge (0 = ACK, 1 = NAK).
- R3: While pending is 1, SCL is held low. Writing a control value with bit 4 = 1 clears pending and launches the next byte or condition. Writing bit 4 = 0 leaves pending set.
- R4: In transmit mode (status bits 7:6 = 11), each release sends the byte that is currently in the data register.
- R5: In receive mode (status bits 7:6 = 10), each release shifts in a byte MSB first, and that byte is readable from the data register once pending is 1. The controller drives the ninth bit low when control bit 7 (ACK enable) is 1, and releases it high (NAK) when that bit is 0.
- R6: A status write with busy = 1 while pending is held is stored and takes no effect until release. The release then produces a repeated START, followed by the data register byte sent as an address byte.
- R7: A status write with busy = 0 during a transfer, followed by a release, produces a STOP. Status bit 5 reads 1 until the STOP has been driven, then reads 0, leaving both lines high.
- R8: One SCL period equals P × (D + 1) clock cycles. P is 16 when control bit 6 is 0 and 512 when it is 1, and D is control bits 3:0.
- R9: irq_o is 1 exactly while pending is 1 and control bit 5 (interrupt enable) is 1.
- R10: A START request made while status bit 4 is 0 is ignored. Busy stays 0 and both lines stay high.
- R11: The own-address register reads back the last value written to it.
- R12: If a release write lands in the same cycle in which a byte completes, pending still becomes 1, and the write neither clears it nor starts another byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register select: 0 control, 1 status, 2 data, 3 own address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| scl_o | output | 1 | SCL drive, 0 pulls low, 1 releases |
| sda_o | output | 1 | SDA drive, 0 pulls low, 1 releases |
| sda_i | input | 1 | Sensed SDA line level |
| irq_o | output | 1 | Interrupt request |

## Verification
Two events can land on the same clock edge: hardware completing a byte and setting pending, and a software write of 1 to the pending bit. The bench first times one reference transfer to find the exact cycle in which pending appears. On a second, identical transfer it places a release write on that same edge. The bench judges the result by two things: pending must read 1 afterwards, and the bus monitor must see SCL held low with no further byte for a long window.

// File: rtl/i2c_mreg_pkg.sv
package i2c_mreg_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_COND, ST_BIT, ST_HOLD} fsm_st_e;
  typedef enum logic [1:0] {CND_START, CND_RSTART, CND_STOP} cond_e;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [1:0] A_OWN  = 2'd3;
  localparam logic [1:0] MODE_RX = 2'b10;
  localparam int DIV_W = 4;
endpackage

// File: rtl/i2c_mreg_tick.sv
module i2c_mreg_tick
  import i2c_mreg_pkg::*;
#(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             pre_sel_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int QMAX  = (PRE_HI / 4) * (2 ** DIV_W);
  localparam int CNT_W = $clog2(QMAX + 1);

  logic [CNT_W-1:0] cnt_q, base, qlen;

  // quarter-bit length minus one
  always_comb begin
    base = pre_sel_i ? CNT_W'(PRE_HI / 4) : CNT_W'(PRE_LO / 4);
    qlen = base * ({{(CNT_W-DIV_W){1'b0}}, div_i} + CNT_W'(1)) - CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q == qlen)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + CNT_W'(1);
  end

  assign tick_o = run_i && (cnt_q == qlen);
endmodule

// File: rtl/i2c_mreg_fsm.sv
module i2c_mreg_fsm
  import i2c_mreg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       go_start_i,
  input  logic       go_rstart_i,
  input  logic       go_stop_i,
  input  logic       go_byte_i,
  input  logic       rx_i,
  input  logic       ack_en_i,
  input  logic       sda_i,
  input  logic       ld_i,
  input  logic [7:0] ld_data_i,
  output logic       run_o,
  output logic       done_o,
  output logic       stop_done_o,
  output logic       scl_o,
  output logic       sda_o,
  output logic [7:0] shreg_o,
  output logic       last_ack_o
);
  fsm_st_e    state_q;
  cond_e      cond_q;
  logic [1:0] q_q;
  logic [3:0] bit_q;
  logic       rx_q, scl_q, sda_q, ack_q;
  logic [7:0] sh_q;
  logic       last_bit;

  assign last_bit    = (bit_q == 4'd8);
  assign run_o       = (state_q == ST_COND) || (state_q == ST_BIT);
  assign done_o      = (state_q == ST_BIT) && tick_i && (q_q == 2'd3) && last_bit;
  assign stop_done_o = (state_q == ST_COND) && (cond_q == CND_STOP) && tick_i && (q_q == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cond_q  <= CND_START;
      q_q     <= '0;
      bit_q   <= '0;
      rx_q    <= 1'b0;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      ack_q   <= 1'b0;
      sh_q    <= '0;
    end else begin
      if (ld_i) sh_q <= ld_data_i;
      unique case (state_q)
        ST_IDLE: if (go_start_i) begin
          state_q <= ST_COND; cond_q <= CND_START; q_q <= '0;
        end
        ST_HOLD: begin
          if (go_stop_i) begin
            state_q <= ST_COND; cond_q <= CND_STOP; q_q <= '0;
          end else if (go_rstart_i) begin
            state_q <= ST_COND; cond_q <= CND_RSTART; q_q <= '0;
          end else if (go_byte_i) begin
            state_q <= ST_BIT; bit_q <= '0; q_q <= '0; rx_q <= rx_i;
          end
        end
        ST_COND: if (tick_i) begin
          q_q <= q_q + 2'd1;
          case (q_q)
            2'd0: sda_q <= (cond_q == CND_RSTART);
            2'd1: if (cond_q != CND_START) scl_q <= 1'b1;
            2'd2: if (cond_q == CND_START) scl_q <= 1'b0;
                  else sda_q <= (cond_q == CND_STOP);
            2'd3: if (cond_q == CND_STOP) state_q <= ST_IDLE;
                  else begin
                    scl_q   <= 1'b0;
                    state_q <= ST_BIT;
                    bit_q   <= '0;
                    rx_q    <= 1'b0;  // address byte always goes out
                  end
          endcase
        end
        ST_BIT: if (tick_i) begin
          q_q <= q_q + 2'd1;
          case (q_q)
            2'd0: sda_q <= last_bit ? (rx_q ? ~ack_en_i : 1'b1) : (rx_q ? 1'b1 : sh_q[7]);
            2'd1: scl_q <= 1'b1;
            2'd2: if (!last_bit) sh_q <= {sh_q[6:0], sda_i};
                  else if (!rx_q) ack_q <= sda_i;
            2'd3: begin
              scl_q <= 1'b0;
              if (last_bit) state_q <= ST_HOLD;
              else bit_q <= bit_q + 4'd1;
            end
          endcase
        end
      endcase
    end
  end

  assign scl_o      = scl_q;
  assign sda_o      = sda_q;
  assign shreg_o    = sh_q;
  assign last_ack_o = ack_q;
endmodule

// File: rtl/i2c_master_regs.sv
module i2c_master_regs
  import i2c_mreg_pkg::*;
#(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 512
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] reg_addr_i,
  input  logic       reg_wr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       scl_o,
  output logic       sda_o,
  input  logic       sda_i,
  output logic       irq_o
);
  logic             ack_en_q, pre_sel_q, irq_en_q, pend_q;
  logic [DIV_W-1:0] div_q;
  logic [1:0]       mode_q;
  logic             busy_q, oen_q, stop_req_q, rst_req_q;
  logic [7:0]       own_q;

  logic wr_ctrl, wr_stat, wr_data, wr_own;
  logic release_w, go_start, go_stop, go_rstart, go_byte;
  logic tick, f_run, f_done, f_stop_done, f_scl, f_sda, f_ack;
  logic [7:0] f_sh;

  assign wr_ctrl = reg_wr_i && (reg_addr_i == A_CTRL);
  assign wr_stat = reg_wr_i && (reg_addr_i == A_STAT);
  assign wr_data = reg_wr_i && (reg_addr_i == A_DATA);
  assign wr_own  = reg_wr_i && (reg_addr_i == A_OWN);

  assign go_start  = wr_stat && !busy_q && reg_wdata_i[5] && reg_wdata_i[4];
  assign release_w = wr_ctrl && reg_wdata_i[4] && pend_q;
  assign go_stop   = release_w && stop_req_q;
  assign go_rstart = release_w && !stop_req_q && rst_req_q;
  assign go_byte   = release_w && !stop_req_q && !rst_req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_en_q <= 1'b0; pre_sel_q <= 1'b0; irq_en_q <= 1'b0; pend_q <= 1'b0;
      div_q <= '0; mode_q <= '0; busy_q <= 1'b0; oen_q <= 1'b0;
      stop_req_q <= 1'b0; rst_req_q <= 1'b0; own_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ack_en_q  <= reg_wdata_i[7];
        pre_sel_q <= reg_wdata_i[6];
        irq_en_q  <= reg_wdata_i[5];
        div_q     <= reg_wdata_i[DIV_W-1:0];
      end
      if (f_done)         pend_q <= 1'b1;  // set wins over a same-cycle clear
      else if (release_w) pend_q <= 1'b0;
      if (wr_stat) begin
        mode_q <= reg_wdata_i[7:6];
        oen_q  <= reg_wdata_i[4];
        if (busy_q) begin
          if (reg_wdata_i[5]) rst_req_q  <= 1'b1;
          else                stop_req_q <= 1'b1;
        end
      end
      if (release_w || go_start) begin
        stop_req_q <= 1'b0;
        rst_req_q  <= 1'b0;
      end
      if (go_start)         busy_q <= 1'b1;
      else if (f_stop_done) busy_q <= 1'b0;
      if (wr_own) own_q <= reg_wdata_i;
    end
  end

  i2c_mreg_tick #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI)) u_tick (
    .clk_i, .rst_ni, .run_i(f_run), .pre_sel_i(pre_sel_q), .div_i(div_q), .tick_o(tick)
  );

  i2c_mreg_fsm u_fsm (
    .clk_i, .rst_ni, .tick_i(tick),
    .go_start_i(go_start), .go_rstart_i(go_rstart), .go_stop_i(go_stop), .go_byte_i(go_byte),
    .rx_i(mode_q == MODE_RX), .ack_en_i(ack_en_q), .sda_i,
    .ld_i(wr_data), .ld_data_i(reg_wdata_i),
    .run_o(f_run), .done_o(f_done), .stop_done_o(f_stop_done),
    .scl_o(f_scl), .sda_o(f_sda), .shreg_o(f_sh), .last_ack_o(f_ack)
  );

  always_comb begin
    unique case (reg_addr_i)
      A_CTRL:  reg_rdata_o = {ack_en_q, pre_sel_q, irq_en_q, pend_q, div_q};
      A_STAT:  reg_rdata_o = {mode_q, busy_q, oen_q, 3'b000, f_ack};
      A_DATA:  reg_rdata_o = f_sh;
      default: reg_rdata_o = own_q;
    endcase
  end

  assign scl_o = oen_q ? f_scl : 1'b1;
  assign sda_o = oen_q ? f_sda : 1'b1;
  assign irq_o = pend_q & irq_en_q;
endmodule

// File: rtl/i2c_master_regs_chk.sv
module i2c_master_regs_chk
  import i2c_mreg_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_wr_i,
  input logic [1:0] reg_addr_i,
  input logic [7:0] reg_wdata_i,
  input logic       scl_o,
  input logic       sda_o,
  input logic       irq_o,
  input logic       pend,
  input logic       busy,
  input logic       oen
);
  assert_idle_released_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (scl_o && sda_o));

  assert_hold_scl_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && oen) |-> !scl_o);

  assert_release_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend && reg_wr_i && reg_addr_i == A_CTRL && reg_wdata_i[4]) |=> !pend);

  assert_irq_on_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (!scl_o || !oen));

  assert_start_by_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(reg_wr_i && reg_addr_i == A_STAT && reg_wdata_i[5] && reg_wdata_i[4]));
endmodule

bind i2c_master_regs i2c_master_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
  .reg_wdata_i(reg_wdata_i), .scl_o(scl_o), .sda_o(sda_o), .irq_o(irq_o),
  .pend(pend_q), .busy(busy_q), .oen(oen_q)
);

// File: tb/i2c_master_regs_test.sv
`timescale 1ns/1ps
module i2c_master_regs_test;
  import i2c_mreg_pkg::*;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       scl_o, sda_o, irq_o;
  logic       slv_sda = 1'b1;
  logic       sda_line;

  always #4 clk = ~clk;

  assign sda_line = sda_o & slv_sda;

  i2c_master_regs uut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_addr_i(reg_addr), .reg_wr_i(reg_wr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .scl_o(scl_o), .sda_o(sda_o),
    .sda_i(sda_line), .irq_o(irq_o)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int last_rise = 0;
  int per = 0;

  always @(posedge clk) cyc++;
  always @(posedge scl_o) begin per = cyc - last_rise; last_rise = cyc; end

  // slave / bus monitor
  int         bit_cnt = 0;
  logic       in_read = 1'b0, is_addr = 1'b0, slv_nak = 1'b0;
  logic [7:0] sh = '0;
  logic [7:0] log_b [0:31];
  logic       mack  [0:31];
  int         log_n = 0, mack_n = 0, start_n = 0, stop_n = 0, rd_idx = 0;

  function automatic logic [7:0] rbyte(input int k);
    return 8'(8'h5A + k * 55);
  endfunction

  always @(negedge sda_line) if (scl_o === 1'b1) begin
    start_n++; bit_cnt = 0; in_read = 1'b0; is_addr = 1'b1;
  end
  always @(posedge sda_line) if (scl_o === 1'b1) stop_n++;

  always @(posedge scl_o) begin
    if (bit_cnt < 8) begin
      sh = {sh[6:0], sda_line}; bit_cnt++;
    end else begin
      bit_cnt = 0;
      if (in_read) begin
        if (mack_n < 32) mack[mack_n] = sda_line;
        mack_n++; rd_idx++;
        if (sda_line) in_read = 1'b0;
      end else begin
        if (log_n < 32) log_b[log_n] = sh;
        log_n++;
        if (is_addr) in_read = sh[0];
        is_addr = 1'b0;
      end
    end
  end

  always @(negedge scl_o) begin
    logic [7:0] b;
    b = rbyte(rd_idx);
    if (bit_cnt == 8)  slv_sda = in_read ? 1'b1 : slv_nak;
    else if (in_read)  slv_sda = b[7 - bit_cnt];
    else               slv_sda = 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_pend(input string req);
    logic [7:0] v;
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk); rd(A_CTRL, v);
      if (v[4]) return;
    end
    chk({req, " pending timeout"}, 0, 1);
  endtask

  task automatic wait_idle(input string req);
    logic [7:0] v;
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk); rd(A_STAT, v);
      if (!v[5]) return;
    end
    chk({req, " busy timeout"}, 0, 1);
  endtask

  task automatic clr_log();
    log_n = 0; mack_n = 0; start_n = 0; stop_n = 0; rd_idx = 0; slv_nak = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    @(negedge clk);
    rd(A_CTRL, v); chk("R1 ctrl", v, 8'h00);
    rd(A_STAT, v); chk("R1 stat", v, 8'h00);
    rd(A_DATA, v); chk("R1 data", v, 8'h00);
    rd(A_OWN, v);  chk("R1 own", v, 8'h00);
    chk("R1 lines/irq", {scl_o, sda_o, irq_o}, 3'b110);
  endtask

  task automatic t_own();
    logic [7:0] v;
    wr(A_OWN, 8'h5C);
    rd(A_OWN, v); chk("R11 own readback", v, 8'h5C);
  endtask

  task automatic t_outdis();
    logic [7:0] v;
    int lows;
    clr_log(); lows = 0;
    wr(A_STAT, 8'hE0);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); if (!scl_o || !sda_o) lows++;
    end
    chk("R10 lines stay high", lows, 0);
    rd(A_STAT, v); chk("R10 busy stays 0", v[5], 0);
    chk("R10 no start", start_n, 0);
  endtask

  task automatic t_write();
    logic [7:0] v;
    int highs;
    clr_log();
    wr(A_CTRL, 8'hA0);
    wr(A_DATA, 8'hA2);
    wr(A_STAT, 8'hF0);
    wait_pend("R2");
    chk("R2 start seen", start_n, 1);
    chk("R2 address byte", log_b[0], 8'hA2);
    rd(A_STAT, v); chk("R2 ack captured", v[0], 0);
    chk("R9 irq while pending", irq_o, 1);
    chk("R8 period div0", per, 16);
    highs = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); if (scl_o) highs++;
    end
    chk("R3 scl held low", highs, 0);
    wr(A_CTRL, 8'hA0);
    rd(A_CTRL, v); chk("R3 bit4=0 keeps pending", v[4], 1);
    wr(A_DATA, 8'h3C);
    wr(A_CTRL, 8'hB0);
    rd(A_CTRL, v); chk("R3 release clears", v[4], 0);
    chk("R9 irq drops", irq_o, 0);
    wait_pend("R4");
    chk("R4 data byte 1", log_b[1], 8'h3C);
    slv_nak = 1'b1;
    wr(A_DATA, 8'hC3);
    wr(A_CTRL, 8'hB0);
    wait_pend("R4");
    slv_nak = 1'b0;
    chk("R4 data byte 2", log_b[2], 8'hC3);
    rd(A_STAT, v); chk("R2 nak captured", v[0], 1);
    wr(A_STAT, 8'hD0);
    rd(A_STAT, v); chk("R7 busy before release", v[5], 1);
    wr(A_CTRL, 8'hB0);
    rd(A_STAT, v); chk("R7 busy during stop", v[5], 1);
    wait_idle("R7");
    chk("R7 stop seen", stop_n, 1);
    chk("R7 lines high", {scl_o, sda_o}, 2'b11);
  endtask

  task automatic t_read();
    logic [7:0] v;
    clr_log();
    wr(A_CTRL, 8'hA0);
    wr(A_DATA, 8'hA2);
    wr(A_STAT, 8'hF0);
    wait_pend("R6");
    wr(A_DATA, 8'h10);
    wr(A_CTRL, 8'hB0);
    wait_pend("R6");
    wr(A_DATA, 8'hA3);
    wr(A_STAT, 8'hB0);
    rd(A_CTRL, v); chk("R6 request waits for release", v[4], 1);
    chk("R6 no start before release", start_n, 1);
    wr(A_CTRL, 8'hB0);
    wait_pend("R6");
    chk("R6 repeated start", start_n, 2);
    chk("R6 read address", log_b[2], 8'hA3);
    wr(A_CTRL, 8'hB0);
    wait_pend("R5");
    rd(A_DATA, v); chk("R5 rx byte 0", v, rbyte(0));
    chk("R5 master ack", mack[0], 0);
    wr(A_CTRL, 8'h30);
    wait_pend("R5");
    rd(A_DATA, v); chk("R5 rx byte 1", v, rbyte(1));
    chk("R5 master nak", mack[1], 1);
    wr(A_STAT, 8'h90);
    wr(A_CTRL, 8'h30);
    wait_idle("R7");
    chk("R7 stop after read", stop_n, 1);
  endtask

  task automatic t_div();
    clr_log();
    wr(A_CTRL, 8'h82);
    wr(A_DATA, 8'hA2);
    wr(A_STAT, 8'hF0);
    wait_pend("R8");
    chk("R8 period div2", per, 48);
    chk("R9 irq off when disabled", irq_o, 0);
    wr(A_STAT, 8'hD0);
    wr(A_CTRL, 8'h92);
    wait_idle("R8");
    wr(A_CTRL, 8'hE0);
    wr(A_DATA, 8'hA2);
    wr(A_STAT, 8'hF0);
    wait_pend("R8");
    chk("R8 period prescale 512", per, 512);
    wr(A_STAT, 8'hD0);
    wr(A_CTRL, 8'hF0);
    wait_idle("R8");
  endtask

  task automatic start_and_count(output int c);
    logic [7:0] v;
    @(negedge clk); reg_addr = A_STAT; reg_wdata = 8'hF0; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    c = 1;
    for (int n = 0; n < 20000; n++) begin
      rd(A_CTRL, v);
      if (v[4]) return;
      @(negedge clk); c++;
    end
  endtask

  task automatic t_race();
    logic [7:0] v;
    int c, lows, n0;
    clr_log();
    wr(A_CTRL, 8'hA0);
    wr(A_DATA, 8'hA2);
    start_and_count(c);
    wr(A_STAT, 8'hD0);
    wr(A_CTRL, 8'hB0);
    wait_idle("R12");
    wr(A_DATA, 8'hA2);
    @(negedge clk); reg_addr = A_STAT; reg_wdata = 8'hF0; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    repeat (c - 2) @(negedge clk);
    reg_addr = A_CTRL; reg_wdata = 8'hB0; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    rd(A_CTRL, v); chk("R12 pending set despite write", v[4], 1);
    n0 = log_n; lows = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); if (scl_o) lows++;
    end
    chk("R12 scl stays low", lows, 0);
    chk("R12 no extra byte", log_n, n0);
    wr(A_STAT, 8'hD0);
    wr(A_CTRL, 8'hB0);
    wait_idle("R12");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_own();
    t_outdis();
    t_write();
    t_read();
    t_div();
    t_race();
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule